// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit holds a bank of count-down timers for every hardware thread of an interleaved pipeline and carries out the deadline instruction. The fetch side tells the unit which thread was given a scheduling slot this cycle. Every timer that belongs to that thread then drops by one and stops at zero.

The decode side presents four things for a deadline instruction: a valid flag, the thread number, the timer index within that thread, and an immediate cycle count. While the selected timer is nonzero, the unit raises a stall. The pipeline replays the same instruction on the thread's next turn, and the replay is judged against the timer as it stands by then. Once the timer reads zero, the instruction loads its immediate into that timer and completes. A timer is never written any other way.

Because a deadline instruction waits for the previous interval to expire before it starts the next one, a code block placed between two deadline instructions takes at least the programmed number of slots.

Top module: `deadline_timer_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every timer of every thread to zero.
- R2: `stall_o` is high exactly when `dec_vld` is high, `dec_tid` names an existing thread, and the selected timer is nonzero in that cycle. With `dec_vld` low, `stall_o` stays low.
- R3: A deadline instruction that is not stalled writes `dec_imm` into the selected timer at the next clock edge.
- R4: In each cycle with `fetch_vld` high, every timer of thread `fetch_tid` decreases by one at the next edge. Timers of other threads do not change, and a `fetch_tid` outside the thread range changes nothing.
- R5: A stalled deadline instruction never loads its timer. Its only change at that edge is the fetch decrement, and a repeated presentation is judged on the updated value.
- R6: A timer at zero stays at zero when its thread is fetched; it never wraps.
- R7: An immediate of 0 loads zero, so the next deadline instruction on that timer proceeds without stalling.
- R8: If one timer is loaded and its thread is fetched in the same cycle, the load wins and the timer holds the immediate.
- R9: `cur_o` shows the current value of the timer chosen by `dec_tid`/`dec_idx` whether or not `dec_vld` is high, and reads 0 for a thread number outside the range.
- R10: With one thread fetched every cycle, a deadline of 6 followed by three other slots and then a deadline of 8 stalls the second deadline for exactly three presentations, then loads 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_vld | input | 1 | A thread was fetched this cycle |
| fetch_tid | input | 3 | Thread that received the fetch slot |
| dec_vld | input | 1 | A deadline instruction is in decode |
| dec_tid | input | 3 | Thread of the decoded deadline instruction |
| dec_idx | input | 1 | Timer index within that thread |
| dec_imm | input | 32 | Immediate cycle count to load |
| stall_o | output | 1 | Stall and replay the deadline instruction |
| cur_o | output | 32 | Current value of the selected timer |

## Verification
A wrong timer value is visible on `cur_o` in the very cycle that timer is selected. It also changes `stall_o` whenever the error crosses the zero boundary. A lost decrement therefore shows as one stall too many on the next replay, and a missed load shows at once as a zero where the immediate was expected. A decrement applied to the wrong thread corrupts a timer the bench reads back during later sweeps, so any cross-thread leak appears within one round of the bank.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } tmr_act_e;

  // Load takes priority over the fetch decrement for the same timer.
  function automatic tmr_act_e pick_act(input logic load_hit, input logic fetch_hit);
    if (load_hit)       return ACT_LOAD;
    else if (fetch_hit) return ACT_DEC;
    else                return ACT_HOLD;
  endfunction

endpackage

// File: rtl/deadline_timer_slot.sv
module deadline_timer_slot #(
  parameter int unsigned TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  dlt_pkg::tmr_act_e  act,
  input  logic [TIMER_W-1:0] imm,
  output logic [TIMER_W-1:0] q
);

  function automatic logic [TIMER_W-1:0] sat_dec(input logic [TIMER_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (act)
        dlt_pkg::ACT_LOAD: q <= imm;
        dlt_pkg::ACT_DEC:  q <= sat_dec(q);
        default:           q <= q;
      endcase
    end
  end

endmodule

// File: rtl/deadline_sel.sv
module deadline_sel #(
  parameter int unsigned NUM_THREADS = 6,
  parameter int unsigned TPT         = 2,
  parameter int unsigned TIMER_W     = 32,
  parameter int unsigned TID_W       = 3,
  parameter int unsigned IDX_W       = 1
) (
  input  logic [NUM_THREADS*TPT*TIMER_W-1:0] tmr_flat,
  input  logic                               dec_vld,
  input  logic [TID_W-1:0]                   dec_tid,
  input  logic [IDX_W-1:0]                   dec_idx,
  output logic [TIMER_W-1:0]                 cur,
  output logic                               stall,
  output logic                               grant
);

  logic tid_ok;
  logic idx_ok;

  always_comb begin
    tid_ok = (32'(dec_tid) < NUM_THREADS);
    idx_ok = (32'(dec_idx) < TPT);
    cur    = '0;
    if (tid_ok && idx_ok)
      cur = tmr_flat[(32'(dec_tid) * TPT + 32'(dec_idx)) * TIMER_W +: TIMER_W];
    stall = dec_vld && tid_ok && idx_ok && (cur != '0);
    grant = dec_vld && tid_ok && idx_ok && (cur == '0);
  end

endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
  parameter int unsigned NUM_THREADS = 6,
  parameter int unsigned TPT         = 2,
  parameter int unsigned TIMER_W     = 32,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned IDX_W      = (TPT > 1) ? $clog2(TPT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_vld,
  input  logic [TID_W-1:0]   fetch_tid,
  input  logic               dec_vld,
  input  logic [TID_W-1:0]   dec_tid,
  input  logic [IDX_W-1:0]   dec_idx,
  input  logic [TIMER_W-1:0] dec_imm,
  output logic               stall_o,
  output logic [TIMER_W-1:0] cur_o
);

  localparam int unsigned N_TMR = NUM_THREADS * TPT;

  logic [N_TMR*TIMER_W-1:0] tmr_flat;
  logic                     load_grant;

  deadline_sel #(
    .NUM_THREADS(NUM_THREADS), .TPT(TPT), .TIMER_W(TIMER_W),
    .TID_W(TID_W), .IDX_W(IDX_W)
  ) u_sel (
    .tmr_flat (tmr_flat),
    .dec_vld  (dec_vld),
    .dec_tid  (dec_tid),
    .dec_idx  (dec_idx),
    .cur      (cur_o),
    .stall    (stall_o),
    .grant    (load_grant)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic fetch_hit;
    assign fetch_hit = fetch_vld && (32'(fetch_tid) == t);
    for (genvar i = 0; i < TPT; i++) begin : g_tmr
      logic              load_hit;
      dlt_pkg::tmr_act_e act;
      assign load_hit = load_grant && (32'(dec_tid) == t) && (32'(dec_idx) == i);
      assign act      = dlt_pkg::pick_act(load_hit, fetch_hit);
      deadline_timer_slot #(.TIMER_W(TIMER_W)) u_slot (
        .clk (clk),
        .rst (rst),
        .act (act),
        .imm (dec_imm),
        .q   (tmr_flat[(t*TPT+i)*TIMER_W +: TIMER_W])
      );
    end
  end

endmodule

// File: rtl/deadline_timer_chk.sv
module deadline_timer_chk #(
  parameter int unsigned NUM_THREADS = 6,
  parameter int unsigned TPT         = 2,
  parameter int unsigned TIMER_W     = 32,
  parameter int unsigned TID_W       = 3,
  parameter int unsigned IDX_W       = 1
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               fetch_vld,
  input logic [TID_W-1:0]                   fetch_tid,
  input logic                               dec_vld,
  input logic [TID_W-1:0]                   dec_tid,
  input logic [IDX_W-1:0]                   dec_idx,
  input logic [TIMER_W-1:0]                 dec_imm,
  input logic                               stall_o,
  input logic [NUM_THREADS*TPT*TIMER_W-1:0] tmr_flat
);

  function automatic logic [TIMER_W-1:0] slice(input logic [TID_W-1:0] t, input logic [IDX_W-1:0] i);
    if (32'(t) >= NUM_THREADS || 32'(i) >= TPT) return '0;
    return tmr_flat[(32'(t) * TPT + 32'(i)) * TIMER_W +: TIMER_W];
  endfunction

  logic sel_ok;
  logic same_thr_fetch;
  logic t0_load;
  assign sel_ok         = (32'(dec_tid) < NUM_THREADS) && (32'(dec_idx) < TPT);
  assign same_thr_fetch = fetch_vld && (fetch_tid == dec_tid);
  assign t0_load        = dec_vld && !stall_o && dec_tid == '0 && dec_idx == '0;

  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= rst ? 1'b1 : seen_rst;

  AST_RESET_CLEAR: assert property (@(posedge clk) seen_rst && $past(rst) |-> tmr_flat == '0) else $error("reset"); // R1
  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (rst) !dec_vld |-> !stall_o) else $error("idle stall"); // R2
  AST_LOAD_ON_ZERO: assert property (@(posedge clk) disable iff (rst) dec_vld && !stall_o && sel_ok |=> slice($past(dec_tid), $past(dec_idx)) == $past(dec_imm)) else $error("load"); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) dec_vld && stall_o && !same_thr_fetch |=> slice($past(dec_tid), $past(dec_idx)) == $past(slice(dec_tid, dec_idx))) else $error("hold"); // R5
  AST_STALL_DEC: assert property (@(posedge clk) disable iff (rst) dec_vld && stall_o && same_thr_fetch |=> slice($past(dec_tid), $past(dec_idx)) == $past(slice(dec_tid, dec_idx)) - 1'b1) else $error("dec"); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst) slice('0, '0) == '0 && !t0_load |=> slice('0, '0) == '0) else $error("wrap"); // R6

endmodule

bind deadline_timer_unit deadline_timer_chk #(
  .NUM_THREADS(NUM_THREADS), .TPT(TPT), .TIMER_W(TIMER_W), .TID_W(TID_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_tid(fetch_tid),
  .dec_vld(dec_vld), .dec_tid(dec_tid), .dec_idx(dec_idx), .dec_imm(dec_imm),
  .stall_o(stall_o), .tmr_flat(tmr_flat)
);

// File: tb/tb_deadline_timer_unit.sv
`timescale 1ns/1ps
module tb_deadline_timer_unit;
  localparam int NT = 6;
  localparam int TP = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_vld;
  logic [2:0]  fetch_tid;
  logic        dec_vld;
  logic [2:0]  dec_tid;
  logic [0:0]  dec_idx;
  logic [31:0] dec_imm;
  logic        stall_o;
  logic [31:0] cur_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] mdl [NT][TP];

  always #2 clk = ~clk;

  deadline_timer_unit dut (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_tid(fetch_tid),
    .dec_vld(dec_vld), .dec_tid(dec_tid), .dec_idx(dec_idx), .dec_imm(dec_imm),
    .stall_o(stall_o), .cur_o(cur_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before the edge, update model after it.
  task automatic step(input logic fv, input int ft, input logic dv, input int dt,
                      input int di, input logic [31:0] imm, input string tag,
                      output logic stalled);
    logic [31:0] e_cur;
    logic        e_stall;
    @(negedge clk);
    fetch_vld = fv; fetch_tid = 3'(ft);
    dec_vld = dv; dec_tid = 3'(dt); dec_idx = 1'(di); dec_imm = imm;
    #1;
    e_cur   = (dt < NT) ? mdl[dt][di] : 32'd0;
    e_stall = dv && (dt < NT) && (e_cur != 0);
    chk({tag, " R9 cur"}, cur_o, e_cur);
    chk({tag, " R2 stall"}, 32'(stall_o), 32'(e_stall));
    stalled = stall_o;
    @(posedge clk);
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < TP; i++)
        if (dv && dt == t && di == i && mdl[t][i] == 0) mdl[t][i] = imm;       // R3 R8
        else if (fv && ft == t && mdl[t][i] != 0) mdl[t][i] = mdl[t][i] - 1;   // R4 R6
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fetch_vld = 0; dec_vld = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < NT; t++) for (int i = 0; i < TP; i++) mdl[t][i] = 0;
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic s;
    int nstall;
    int seed;
    rst = 0; fetch_vld = 0; fetch_tid = 0; dec_vld = 0; dec_tid = 0; dec_idx = 0; dec_imm = 0;
    do_reset();
    // R1: all timers read zero after reset
    for (int t = 0; t < 8; t++) for (int i = 0; i < TP; i++) step(0, 0, 0, t, i, 0, "R1 reset", s);

    // R3: load every timer with a distinct value, no fetch
    for (int t = 0; t < NT; t++) for (int i = 0; i < TP; i++) step(0, 0, 1, t, i, 32'(2 + 2*t + i), "R3 load", s);
    // R5: stalled instructions must not reload
    for (int t = 0; t < NT; t++) step(0, 0, 1, t, 1, 32'd99, "R5 hold", s);
    // R4/R6: round-robin fetch incl. out-of-range thread numbers, peeking timers
    for (int c = 0; c < 160; c++) step(1, c % 8, 0, (c / 8) % NT, c % TP, 0, "R4 R6 decay", s);
    // R7: zero immediate
    step(0, 0, 1, 3, 0, 32'd0, "R7 zero load", s);
    step(0, 0, 1, 3, 0, 32'd5, "R7 next proceeds", s);
    chk("R7 no stall", 32'(s), 32'd0);
    // R8: load and fetch on same timer same cycle
    step(1, 2, 1, 2, 1, 32'd7, "R8 load vs fetch", s);
    step(0, 0, 0, 2, 1, 0, "R8 readback", s);
    chk("R8 value", cur_o, 32'd7);
    // wide value
    step(0, 0, 1, 5, 0, 32'hFFFF_FFFF, "R3 wide", s);
    step(0, 0, 0, 5, 0, 0, "R3 wide read", s);

    // Mixed sweep with replays on all threads
    seed = 17;
    for (int c = 0; c < 3000; c++) begin
      seed = (seed * 1103 + 12345) % 65521;
      step(seed[0], (seed >> 1) % 8, seed[4] | seed[5], (seed >> 6) % 7, seed[9], 32'((seed >> 10) % 9),
           "R2 R3 R4 R5 sweep", s);
    end

    // R10: the 6 / three slots / 8 trace on thread 4, fetched every cycle
    do_reset();
    step(1, 4, 1, 4, 0, 32'd6, "R10 first deadline", s);
    for (int k = 0; k < 3; k++) step(1, 4, 0, 4, 0, 0, "R10 body", s);
    nstall = 0;
    s = 1'b1;
    while (s && nstall < 20) begin
      step(1, 4, 1, 4, 0, 32'd8, "R10 second deadline", s);
      if (s) nstall++;
    end
    chk("R10 stall count", 32'(nstall), 32'd3);
    step(0, 0, 0, 4, 0, 0, "R10 reload", s);
    chk("R10 timer", cur_o, 32'd8);

    // R1: reset mid-run clears loaded timers
    do_reset();
    for (int t = 0; t < NT; t++) step(0, 0, 0, t, 0, 0, "R1 re-reset", s);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule